// File: doc/BRIEF.md
# Parallel Channel Destination Connection Controller

This block is the connection-side controller of a receiving endpoint on a parallel point-to-point channel. It watches the source's REQUEST, PACKET and BURST lines and the line that shows the source interconnect is up. It reports a pending connection request to the host together with the captured I-field word, and takes the host's accept or reject decision. It then drives the CONNECT line back to the source. A 3-bit phase code tells the host which state the controller is in and what the data word currently means.

After a power-on reset or a reset command, the block stays halted until the host issues an enable command. In the halt state CONNECT is low and the host-side outputs are marked undriven. Once enabled, the block loops through three disconnected phases, each with its own status word. A connection ends up either connected (an idle state that tracks packets) or rejected (a timed CONNECT pulse). A packet that closes without carrying any burst sets a sticky sequence-error flag.

The channel inputs are taken to be synchronous to `clk` already. The data path and the READY flow control live outside this block.

Top module: `chdst_conn_ctrl`

## Requirements
- R1: After `rst_n` low, or after a reset command (`cmd_valid` with `cmd_code` = 0) in any state, the block is halted. `ch_connect`, `host_drive_en`, `host_data`, `sel_code`, `conn_req`, `pkt_flag`, `src_avail` and `seq_err` all read 0. The block stays halted until an enable command (`cmd_code` = 5) arrives.
- R2: The enable command moves the block into the disconnected loop. `sel_code` then reads 5, 6, 7, 5, ... with one clock per phase, and the loop starts at 5.
- R3: In the disconnected loop, `host_data` carries a status word that depends on the phase. In phase 5, bit 0 is `seq_err` and all other bits are 0. In phase 6, bits [3:0] are {burst, packet, request, interconnect}, sampled at the edge that entered the phase, and all other bits are 0. In phase 7, the word is 0.
- R4: While enabled, `src_avail` equals `ch_ic_up` AND NOT (`ch_request` OR `ch_packet` OR `ch_burst`), sampled at the previous clock edge.
- R5: In the disconnected loop with `host_con` low, a high `ch_request` moves the block to request-pending. In that state `sel_code` is 1 and `conn_req` is 1, and `host_data` holds the `ch_data` word sampled at that edge until the state is left. If the request drops while pending, the block returns to the loop.
- R6: When pending, `host_con` = 1 with `host_accept` = 1 raises `ch_connect`. The phase code then loops 5, 6, 7, 5 for four clocks, after which `sel_code` is 3 with `ch_connect` still high.
- R7: When pending, `host_con` = 1 with `host_accept` = 0 drives `ch_connect` high for 4 clocks and then low for 4 clocks. `ch_connect` stays low while the request is held. The block returns to the loop once the request is low at or after the end of the pattern.
- R8: While `host_con` is high in the disconnected loop, a request is ignored: `conn_req` stays 0. It is taken on the first edge at which `host_con` is low.
- R9: When connected and idle, a high `ch_packet` sets `pkt_flag` with `sel_code` at 3. `pkt_flag` clears when the packet ends after at least one burst, and `seq_err` stays unchanged.
- R10: If the packet drops before any burst has begun, `seq_err` is set. It stays set until `status_clr` or a reset.
- R11: If `ch_request` drops while connected, `ch_connect` goes low at the next edge and the block returns to the disconnected loop at phase 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command: 0 reset, 5 enable, others ignored |
| ch_ic_up | input | 1 | Source interconnect active |
| ch_request | input | 1 | Source REQUEST line |
| ch_packet | input | 1 | Source PACKET line |
| ch_burst | input | 1 | Source BURST line |
| ch_data | input | DW | Channel data word (I-field during a request) |
| host_con | input | 1 | Host connect decision strobe / enable gate |
| host_accept | input | 1 | 1 accept, 0 reject |
| status_clr | input | 1 | Clears the sequence-error flag |
| ch_connect | output | 1 | CONNECT line to the source |
| host_drive_en | output | 1 | Host-side outputs driven (0 means tri-stated) |
| host_data | output | DW | I-field or status word |
| sel_code | output | 3 | Phase code: 0 halt, 1 pending, 3 connected, 5/6/7 disconnected |
| conn_req | output | 1 | Connection request pending |
| src_avail | output | 1 | Functional, quiet source present |
| pkt_flag | output | 1 | Packet in progress |
| seq_err | output | 1 | Sticky empty-packet error |

## Verification
Every output of this controller is a decode of registered state or a registered sample, so any result is due exactly one rising edge after the inputs that cause it. This holds for phase changes, the CONNECT pattern, the captured I-field, the line snapshot and the availability flag. The bench drives inputs on the falling edge and compares outputs on the next falling edge. The reject pattern is then checked clock by clock against its 4-high, 4-low count, the accept hold against its four looping phases, and the error flag against the single edge at which the empty packet closes.

// File: rtl/chdst_pkg.sv
package chdst_pkg;

   typedef enum logic [2:0] {
      ST_HALT,
      ST_DISC,
      ST_REQ,
      ST_REJ,
      ST_ACC,
      ST_IDLE,
      ST_PKTW,
      ST_PKTB
   } st_e;

   localparam logic [2:0] CMD_RESET  = 3'd0;
   localparam logic [2:0] CMD_ENABLE = 3'd5;

   localparam logic [2:0] SEL_HALT = 3'd0;
   localparam logic [2:0] SEL_REQ  = 3'd1;
   localparam logic [2:0] SEL_CONN = 3'd3;
   localparam logic [2:0] SEL_PH0  = 3'd5;

   function automatic logic is_cycling(st_e s);
      return (s == ST_DISC) || (s == ST_REJ) || (s == ST_ACC);
   endfunction

endpackage

// File: rtl/chdst_timer.sv
module chdst_timer #(
   parameter int W    = 3,
   parameter int MAXV = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] TOP = W'(MAXV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (clr)      q <= '0;
      else if (q != TOP) q <= q + 1'b1;
   end
endmodule

// File: rtl/chdst_phase.sv
module chdst_phase (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       adv,
   output logic [1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= 2'd0;
      else if (!adv)       q <= 2'd0;
      else if (q == 2'd2)  q <= 2'd0;
      else                 q <= q + 2'd1;
   end
endmodule

// File: rtl/chdst_avail.sv
module chdst_avail #(
   parameter bit REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ic_up,
   input  logic req,
   input  logic pkt,
   input  logic bst,
   output logic avail
);
   logic quiet;
   assign quiet = ic_up && !(req || pkt || bst);

   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) avail <= 1'b0;
            else        avail <= quiet;
         end
      end else begin : g_comb
         assign avail = quiet;
      end
   endgenerate
endmodule

// File: rtl/chdst_host_mux.sv
module chdst_host_mux
   import chdst_pkg::*;
#(
   parameter int DW = 32
) (
   input  st_e           st,
   input  logic [1:0]    ph,
   input  logic [DW-1:0] ifield,
   input  logic          err,
   input  logic [3:0]    lines,
   output logic [DW-1:0] data,
   output logic [2:0]    sel
);
   always_comb begin
      data = '0;
      sel  = SEL_HALT;
      case (st)
         ST_REQ: begin
            sel  = SEL_REQ;
            data = ifield;
         end
         ST_DISC, ST_REJ, ST_ACC: begin
            sel = SEL_PH0 + {1'b0, ph};
            case (ph)
               2'd0:    data[0]   = err;
               2'd1:    data[3:0] = lines;
               default: data      = '0;
            endcase
         end
         ST_IDLE, ST_PKTW, ST_PKTB: sel = SEL_CONN;
         default: begin
            data = '0;
            sel  = SEL_HALT;
         end
      endcase
   end
endmodule

// File: rtl/chdst_conn_ctrl.sv
module chdst_conn_ctrl
   import chdst_pkg::*;
#(
   parameter int DW        = 32,
   parameter int CONN_ON   = 4,
   parameter int CONN_OFF  = 4,
   parameter int ACC_HOLD  = 4,
   parameter bit AVAIL_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [2:0]    cmd_code,
   input  logic          ch_ic_up,
   input  logic          ch_request,
   input  logic          ch_packet,
   input  logic          ch_burst,
   input  logic [DW-1:0] ch_data,
   input  logic          host_con,
   input  logic          host_accept,
   input  logic          status_clr,
   output logic          ch_connect,
   output logic          host_drive_en,
   output logic [DW-1:0] host_data,
   output logic [2:0]    sel_code,
   output logic          conn_req,
   output logic          src_avail,
   output logic          pkt_flag,
   output logic          seq_err
);
   localparam int REJ_LAST = CONN_ON + CONN_OFF - 1;
   localparam int ACC_LAST = ACC_HOLD - 1;
   localparam int CNT_MAX  = (REJ_LAST > ACC_LAST) ? REJ_LAST : ACC_LAST;
   localparam int CW       = (CNT_MAX < 1) ? 1 : $clog2(CNT_MAX + 1);

   generate
      if (DW < 8) begin : g_bad_dw
         $error("chdst_conn_ctrl: DW must be at least 8");
      end
      if (CONN_ON < 1 || CONN_OFF < 1) begin : g_bad_rej
         $error("chdst_conn_ctrl: CONNECT reject phases need at least one cycle");
      end
      if (ACC_HOLD < 1) begin : g_bad_acc
         $error("chdst_conn_ctrl: ACC_HOLD must be at least 1");
      end
   endgenerate

   st_e           st, nxt;
   logic [CW-1:0] cnt;
   logic [1:0]    ph;
   logic [DW-1:0] ifield_q;
   logic [3:0]    lines_q;
   logic          err_q, err_set, cap, avail_raw;
   logic          rst_cmd, en_cmd;

   assign rst_cmd = cmd_valid && (cmd_code == CMD_RESET);
   assign en_cmd  = cmd_valid && (cmd_code == CMD_ENABLE);

   always_comb begin
      nxt     = st;
      err_set = 1'b0;
      cap     = 1'b0;
      if (rst_cmd) begin
         nxt = ST_HALT;
      end else begin
         case (st)
            ST_HALT: if (en_cmd) nxt = ST_DISC;
            ST_DISC: if (ch_request && !host_con) begin
               nxt = ST_REQ;
               cap = 1'b1;
            end
            ST_REQ: begin
               if (!ch_request)   nxt = ST_DISC;
               else if (host_con) nxt = host_accept ? ST_ACC : ST_REJ;
            end
            ST_REJ: if (cnt >= CW'(REJ_LAST) && !ch_request) nxt = ST_DISC;
            ST_ACC: begin
               if (!ch_request)                nxt = ST_DISC;
               else if (cnt >= CW'(ACC_LAST))  nxt = ST_IDLE;
            end
            ST_IDLE: begin
               if (!ch_request)    nxt = ST_DISC;
               else if (ch_packet) nxt = ST_PKTW;
            end
            ST_PKTW: begin
               if (!ch_request)     nxt = ST_DISC;
               else if (ch_burst)   nxt = ST_PKTB;
               else if (!ch_packet) begin
                  nxt     = ST_IDLE;
                  err_set = 1'b1;
               end
            end
            ST_PKTB: begin
               if (!ch_request)                   nxt = ST_DISC;
               else if (!ch_packet && !ch_burst)  nxt = ST_IDLE;
            end
            default: nxt = ST_HALT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_HALT;
         ifield_q <= '0;
         lines_q  <= '0;
         err_q    <= 1'b0;
      end else begin
         st      <= nxt;
         lines_q <= {ch_burst, ch_packet, ch_request, ch_ic_up};
         if (cap) ifield_q <= ch_data;
         if (rst_cmd)         err_q <= 1'b0;
         else if (err_set)    err_q <= 1'b1;
         else if (status_clr) err_q <= 1'b0;
      end
   end

   chdst_timer #(.W(CW), .MAXV(CNT_MAX)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (nxt != st),
      .q     (cnt)
   );

   chdst_phase u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (is_cycling(st) && is_cycling(nxt)),
      .q     (ph)
   );

   chdst_avail #(.REGISTERED(AVAIL_REG)) u_avail (
      .clk   (clk),
      .rst_n (rst_n),
      .ic_up (ch_ic_up),
      .req   (ch_request),
      .pkt   (ch_packet),
      .bst   (ch_burst),
      .avail (avail_raw)
   );

   chdst_host_mux #(.DW(DW)) u_mux (
      .st     (st),
      .ph     (ph),
      .ifield (ifield_q),
      .err    (err_q),
      .lines  (lines_q),
      .data   (host_data),
      .sel    (sel_code)
   );

   always_comb begin
      case (st)
         ST_REJ:                    ch_connect = (cnt < CW'(CONN_ON));
         ST_ACC, ST_IDLE,
         ST_PKTW, ST_PKTB:          ch_connect = 1'b1;
         default:                   ch_connect = 1'b0;
      endcase
   end

   assign host_drive_en = (st != ST_HALT);
   assign conn_req      = (st == ST_REQ);
   assign pkt_flag      = (st == ST_PKTW) || (st == ST_PKTB);
   assign src_avail     = host_drive_en && avail_raw;
   assign seq_err       = err_q;

endmodule

// File: rtl/chdst_conn_ctrl_chk.sv
module chdst_conn_ctrl_chk #(
   parameter int DW        = 32,
   parameter bit AVAIL_REG = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic [2:0]    cmd_code,
   input logic          ch_ic_up,
   input logic          ch_request,
   input logic          ch_packet,
   input logic          ch_burst,
   input logic          host_con,
   input logic          status_clr,
   input logic          ch_connect,
   input logic          host_drive_en,
   input logic [DW-1:0] host_data,
   input logic [2:0]    sel_code,
   input logic          conn_req,
   input logic          src_avail,
   input logic          pkt_flag,
   input logic          seq_err
);
   AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !host_drive_en |-> (!ch_connect && sel_code == 3'd0 && host_data == '0 && !seq_err && !src_avail)); // R1

   AST_RESET_CMD_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 3'd0) |=> (!host_drive_en && !seq_err)); // R1

   AST_ENABLE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_drive_en && cmd_valid && cmd_code == 3'd5) |=> (sel_code == 3'd5)); // R2

   AST_PHASE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_code == 3'd6) |=> (sel_code != 3'd6)); // R2

   generate
      if (AVAIL_REG) begin : g_av
         AST_AVAIL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            host_drive_en |-> (src_avail == $past(ch_ic_up && !ch_request && !ch_packet && !ch_burst))); // R4
      end
   endgenerate

   AST_REQ_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      conn_req |-> (sel_code == 3'd1 && !ch_connect)); // R5

   AST_IDLE_CONNECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_code == 3'd3) |-> ch_connect); // R6

   AST_DISABLED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_code inside {3'd5, 3'd6, 3'd7} && !ch_connect && host_con && !cmd_valid) |=> !conn_req); // R8

   AST_PKT_IN_CONN: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_flag |-> (sel_code == 3'd3 && ch_connect)); // R9

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_err && !status_clr && !cmd_valid) |=> seq_err); // R10

   AST_LOSS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_connect && sel_code == 3'd3 && !ch_request && !cmd_valid) |=> (!ch_connect && sel_code == 3'd5)); // R11
endmodule

bind chdst_conn_ctrl chdst_conn_ctrl_chk #(.DW(DW), .AVAIL_REG(AVAIL_REG)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_valid     (cmd_valid),
   .cmd_code      (cmd_code),
   .ch_ic_up      (ch_ic_up),
   .ch_request    (ch_request),
   .ch_packet     (ch_packet),
   .ch_burst      (ch_burst),
   .host_con      (host_con),
   .status_clr    (status_clr),
   .ch_connect    (ch_connect),
   .host_drive_en (host_drive_en),
   .host_data     (host_data),
   .sel_code      (sel_code),
   .conn_req      (conn_req),
   .src_avail     (src_avail),
   .pkt_flag      (pkt_flag),
   .seq_err       (seq_err)
);

// File: tb/chdst_conn_ctrl_bench.sv
`timescale 1ns/1ps
module chdst_conn_ctrl_bench;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_code = 3'd7;
   logic          ch_ic_up = 1'b1, ch_request = 1'b0, ch_packet = 1'b0, ch_burst = 1'b0;
   logic [DW-1:0] ch_data = '0;
   logic          host_con = 1'b0, host_accept = 1'b0, status_clr = 1'b0;
   logic          ch_connect, host_drive_en, conn_req, src_avail, pkt_flag, seq_err;
   logic [DW-1:0] host_data;
   logic [2:0]    sel_code;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   chdst_conn_ctrl #(.DW(DW)) u_chdst_conn_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .ch_ic_up(ch_ic_up), .ch_request(ch_request), .ch_packet(ch_packet),
      .ch_burst(ch_burst), .ch_data(ch_data), .host_con(host_con),
      .host_accept(host_accept), .status_clr(status_clr),
      .ch_connect(ch_connect), .host_drive_en(host_drive_en), .host_data(host_data),
      .sel_code(sel_code), .conn_req(conn_req), .src_avail(src_avail),
      .pkt_flag(pkt_flag), .seq_err(seq_err)
   );

   // cmd: 0 none, 1 reset command, 2 enable command
   typedef struct packed {
      logic [1:0] cmd;
      logic req, pkt, bst, ic, con, acc, clr;
      logic [2:0] sel;
      logic cn, cr, pk, er, av;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t TBL [NV] = '{
      '{2'd2, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 3'd5, 1'b0,1'b0,1'b0,1'b0,1'b1},
      '{2'd0, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 3'd6, 1'b0,1'b0,1'b0,1'b0,1'b1},
      '{2'd0, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 3'd7, 1'b0,1'b0,1'b0,1'b0,1'b1},
      '{2'd0, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 3'd5, 1'b0,1'b0,1'b0,1'b0,1'b1},
      '{2'd0, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 3'd1, 1'b0,1'b1,1'b0,1'b0,1'b0},
      '{2'd0, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 3'd5, 1'b1,1'b0,1'b0,1'b0,1'b0},
      '{2'd0, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 3'd6, 1'b1,1'b0,1'b0,1'b0,1'b0},
      '{2'd0, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 3'd7, 1'b1,1'b0,1'b0,1'b0,1'b0},
      '{2'd0, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 3'd5, 1'b1,1'b0,1'b0,1'b0,1'b0},
      '{2'd0, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 3'd3, 1'b1,1'b0,1'b0,1'b0,1'b0},
      '{2'd0, 1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0, 3'd3, 1'b1,1'b0,1'b1,1'b0,1'b0},
      '{2'd0, 1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0, 3'd3, 1'b1,1'b0,1'b1,1'b0,1'b0},
      '{2'd0, 1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0, 3'd3, 1'b1,1'b0,1'b1,1'b0,1'b0},
      '{2'd0, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 3'd3, 1'b1,1'b0,1'b0,1'b0,1'b0},
      '{2'd0, 1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0, 3'd3, 1'b1,1'b0,1'b1,1'b0,1'b0},
      '{2'd0, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 3'd3, 1'b1,1'b0,1'b0,1'b1,1'b0},
      '{2'd0, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 3'd5, 1'b0,1'b0,1'b0,1'b1,1'b1},
      '{2'd0, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 3'd6, 1'b0,1'b0,1'b0,1'b0,1'b1}
   };

   function automatic string row_req(int i);
      if (i < 4)   return "R2";
      if (i == 4)  return "R5";
      if (i < 10)  return "R6";
      if (i < 14)  return "R9";
      if (i == 16) return "R11";
      return "R10";
   endfunction

   task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drive(logic [1:0] cmd, logic req, logic pkt, logic bst, logic ic,
                        logic con, logic acc, logic clr);
      cmd_valid   = (cmd != 2'd0);
      cmd_code    = (cmd == 2'd1) ? 3'd0 : (cmd == 2'd2) ? 3'd5 : 3'd7;
      ch_request  = req;
      ch_packet   = pkt;
      ch_burst    = bst;
      ch_ic_up    = ic;
      host_con    = con;
      host_accept = acc;
      status_clr  = clr;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: power-on reset state, interconnect up but block halted
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      step();
      chk("R1", "reset connect/drive/sel", {ch_connect, host_drive_en, sel_code}, '0);
      chk("R1", "reset data", host_data, '0);
      chk("R1", "reset avail/req/err", {src_avail, conn_req, seq_err, pkt_flag}, '0);
      repeat (3) step();
      chk("R1", "halt without enable", {host_drive_en, sel_code}, '0);

      // Vector table: enable, accept, packets, empty packet, loss, clear
      for (int i = 0; i < NV; i++) begin
         drive(TBL[i].cmd, TBL[i].req, TBL[i].pkt, TBL[i].bst, TBL[i].ic,
               TBL[i].con, TBL[i].acc, TBL[i].clr);
         step();
         chk(row_req(i), $sformatf("row %0d sel/cn/cr/pk/er", i),
             {sel_code, ch_connect, conn_req, pkt_flag, seq_err},
             {TBL[i].sel, TBL[i].cn, TBL[i].cr, TBL[i].pk, TBL[i].er});
         chk("R4", $sformatf("row %0d avail", i), src_avail, TBL[i].av);
      end

      // R3: status words by phase (currently in phase 6)
      drive(2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      step();
      chk("R3", "phase 7 word", {sel_code, host_data}, {3'd7, 32'h0});
      drive(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      step();
      chk("R3", "phase 5 word", {sel_code, host_data}, {3'd5, 32'h0});
      drive(2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      step();
      chk("R3", "phase 6 line snapshot", {sel_code, host_data}, {3'd6, 32'h5});
      chk("R4", "avail low with packet", src_avail, 1'b0);

      // R5: I-field capture and hold
      ch_data = 32'hA5A5_0001;
      drive(2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      step();
      chk("R5", "pending sel/req", {sel_code, conn_req}, {3'd1, 1'b1});
      chk("R5", "captured ifield", host_data, 32'hA5A5_0001);
      ch_data = 32'hFFFF_FFFF;
      step();
      chk("R5", "ifield held", host_data, 32'hA5A5_0001);

      // R7: reject pattern
      drive(2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
      for (int k = 0; k < 8; k++) begin
         step();
         chk("R7", $sformatf("reject connect cycle %0d", k), ch_connect, (k < 4) ? 1'b1 : 1'b0);
      end
      step();
      chk("R7", "held request keeps connect low", {ch_connect, conn_req}, 2'b00);
      drive(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
      step();
      chk("R7", "back in loop", {ch_connect, conn_req, (sel_code >= 3'd5)}, 3'b001);

      // R8: disabled while host_con high
      drive(2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
      for (int k = 0; k < 3; k++) begin
         step();
         chk("R8", $sformatf("request ignored %0d", k), {conn_req, ch_connect}, 2'b00);
      end
      host_con = 1'b0;
      step();
      chk("R8", "request taken once enabled", {sel_code, conn_req}, {3'd1, 1'b1});

      // R5: withdrawn request
      ch_request = 1'b0;
      step();
      chk("R5", "withdrawn request", {conn_req, (sel_code >= 3'd5)}, 2'b01);

      // R1: reset command while connected, then re-enable (R2)
      drive(2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      step();
      drive(2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
      repeat (5) step();
      chk("R6", "connected idle", {sel_code, ch_connect}, {3'd3, 1'b1});
      drive(2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
      step();
      chk("R1", "reset command halts", {ch_connect, host_drive_en, sel_code}, '0);
      drive(2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      step();
      chk("R2", "re-enable", {host_drive_en, sel_code}, {1'b1, 3'd5});
      cmd_valid = 1'b0;

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule